// File: doc/BRIEF.md
# Channel-Status and Error Flag Output Unit

This unit sits behind the decoder of a digital audio interface receiver. For each decoded subframe it receives the validity, user and channel-status bits, together with a flag that marks the preamble opening a channel-status block. It also takes asynchronous strobes for parity errors and biphase violations, and a level that says whether the receiver clock is in lock. It turns this information into five side outputs that run alongside a serial audio port:
- the channel-status bit;
- the user bit;
- a block marker;
- an error flag;
- a validity-plus-error flag.

The unit keeps its own position inside the 192-frame channel-status block. The counter is resynchronised by the block-start flag and held at zero while lock is lost. The block marker is high for the first 32 frames of each block, so its rising edge shows where a new block begins.

The port timing arrives as two single-cycle strobes. `earlyTick` marks the point one bit-clock period before the active frame-sync edge. `syncTick` marks the active frame-sync edge itself. `fmtOnEdge` selects where the C, U and marker outputs change:
- early, so that the frame-sync edge can latch them (non-I2S formats);
- on the frame-sync edge (I2S-style formats).

The error outputs always change on the frame-sync edge.

Top module: `cs_flag_out`

## Requirements
- R1: While `rstN` is low, every output is low and the position counter is at frame 0, left subframe. After reset, the first subframe that arrives without `blockStart` is frame 0, so the marker it produces is high.
- R2: The block marker for a subframe is 1 in frames 0 to 31 (64 subframes) and 0 in frames 32 to 191 (320 subframes). A left and a right subframe make one frame. After frame 191, right, the count wraps to frame 0 without any `blockStart`.
- R3: A subframe that arrives with `blockStart` = 1 is taken as frame 0, left, whatever the count was before. The count then continues from that point.
- R4: At a `syncTick`, `erfOut` is set to 1 in either case:
  - a `parityErr` or `biphaseErr` strobe occurred in any cycle after the previous `syncTick`, up to the cycle before this one;
  - `locked` is 0.
  Otherwise `erfOut` is set to 0. The error memory is cleared when it is transferred.
- R5: `verfOut` takes the value (validity bit of the most recently captured subframe) OR (the new `erfOut`), at the same edge as `erfOut`.
- R6: `erfOut` and `verfOut` change only in the cycle after a `syncTick`, in both formats.
- R7: With `fmtOnEdge` = 0, `cOut`, `uOut` and `cblOut` take the latest subframe's values in the cycle after `earlyTick`. A `syncTick` leaves them unchanged.
- R8: With `fmtOnEdge` = 1, `cOut`, `uOut` and `cblOut` take the latest subframe's values in the cycle after `syncTick`. An `earlyTick` leaves them unchanged.
- R9: While `locked` is 0:
  - `erfOut` and `verfOut` are 1 after every `syncTick`;
  - the position counter is held at frame 0, left.
  After lock returns, the first subframe without `blockStart` is frame 0, left, so its marker is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtOnEdge | input | 1 | 1: C/U/marker change on the frame-sync edge; 0: one bit period earlier |
| subStrobe | input | 1 | One-cycle pulse: a decoded subframe's side bits are valid |
| blockStart | input | 1 | With `subStrobe`: this subframe follows the block-start preamble |
| vIn | input | 1 | Validity bit of the subframe |
| uIn | input | 1 | User bit of the subframe |
| cIn | input | 1 | Channel-status bit of the subframe |
| parityErr | input | 1 | One-cycle parity error strobe |
| biphaseErr | input | 1 | One-cycle biphase coding violation strobe |
| locked | input | 1 | Receiver clock recovery is in lock |
| earlyTick | input | 1 | One-cycle pulse one bit period before the active frame-sync edge |
| syncTick | input | 1 | One-cycle pulse at the active frame-sync edge |
| cOut | output | 1 | Channel-status bit output |
| uOut | output | 1 | User bit output |
| cblOut | output | 1 | Channel-status block marker |
| erfOut | output | 1 | Error flag |
| verfOut | output | 1 | Validity OR error flag |

## Verification
A wrong position count does not show at once. It appears as a shifted or stretched marker pulse, which may surface only at the 32-frame boundary or at the wrap after frame 191. For that reason a full block of 384 subframes is run, and the marker pulse is counted and checked for its length and for where it starts. A stuck or uncleared error memory shows at the next frame-sync edge as an `erfOut` that stays high one subframe too long. A swapped update point shows within a single subframe: C and U either move at the wrong strobe or fail to move at the right one.

// File: rtl/cs_flag_pkg.sv
package cs_flag_pkg;
  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic capture;   // latch the incoming subframe side bits
    logic marker;    // block-marker value for the subframe being latched
    logic sideLoad;  // move C/U/marker to the outputs
    logic flagLoad;  // move error state to ERF/VERF
  } ctrlStrobes_t;
endpackage

// File: rtl/cs_flag_ctrl.sv
module cs_flag_ctrl
  import cs_flag_pkg::*;
#(
  parameter int FRAMES      = 192,
  parameter int MARK_FRAMES = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         fmtOnEdge,
  input  logic         subStrobe,
  input  logic         blockStart,
  input  logic         locked,
  input  logic         earlyTick,
  input  logic         syncTick,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(FRAMES);
  localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(FRAMES - 1);
  localparam logic [CNT_W-1:0] MARK_END   = CNT_W'(MARK_FRAMES);

  logic [CNT_W-1:0] frameCnt;
  logic             rightHalf;
  logic [CNT_W-1:0] posFrame;
  logic             posRight;

  // Position of the subframe being presented now
  always_comb begin
    if (blockStart || !locked) begin
      posFrame = '0;
      posRight = 1'b0;
    end else begin
      posFrame = frameCnt;
      posRight = rightHalf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !locked) begin
      frameCnt  <= '0;
      rightHalf <= 1'b0;
    end else if (subStrobe) begin
      rightHalf <= ~posRight;
      if (posRight)
        frameCnt <= (posFrame == LAST_FRAME) ? '0 : posFrame + 1'b1;
      else
        frameCnt <= posFrame;
    end
  end

  always_comb begin
    strobes.capture  = subStrobe;
    strobes.marker   = (posFrame < MARK_END);
    strobes.sideLoad = fmtOnEdge ? syncTick : earlyTick;
    strobes.flagLoad = syncTick;
  end
endmodule

// File: rtl/cs_flag_dp.sv
module cs_flag_dp
  import cs_flag_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         vIn,
  input  logic         uIn,
  input  logic         cIn,
  input  logic         parityErr,
  input  logic         biphaseErr,
  input  logic         locked,
  output logic         cOut,
  output logic         uOut,
  output logic         cblOut,
  output logic         erfOut,
  output logic         verfOut
);
  logic pendV, pendU, pendC, pendCbl;
  logic stickyErr;
  logic errNow;
  logic flagNext;

  assign errNow   = parityErr | biphaseErr;
  assign flagNext = stickyErr | ~locked;

  // Capture of the latest subframe's side bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendV   <= 1'b0;
      pendU   <= 1'b0;
      pendC   <= 1'b0;
      pendCbl <= 1'b0;
    end else if (strobes.capture) begin
      pendV   <= vIn;
      pendU   <= uIn;
      pendC   <= cIn;
      pendCbl <= strobes.marker;
    end
  end

  // Sticky error memory, emptied into ERF at the frame-sync edge
  always_ff @(posedge clk) begin
    if (!rstN)
      stickyErr <= 1'b0;
    else if (strobes.flagLoad)
      stickyErr <= errNow;
    else
      stickyErr <= stickyErr | errNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      erfOut  <= 1'b0;
      verfOut <= 1'b0;
    end else if (strobes.flagLoad) begin
      erfOut  <= flagNext;
      verfOut <= pendV | flagNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cOut   <= 1'b0;
      uOut   <= 1'b0;
      cblOut <= 1'b0;
    end else if (strobes.sideLoad) begin
      cOut   <= pendC;
      uOut   <= pendU;
      cblOut <= pendCbl;
    end
  end
endmodule

// File: rtl/cs_flag_out.sv
module cs_flag_out
  import cs_flag_pkg::*;
#(
  parameter int FRAMES      = 192,
  parameter int MARK_FRAMES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic fmtOnEdge,
  input  logic subStrobe,
  input  logic blockStart,
  input  logic vIn,
  input  logic uIn,
  input  logic cIn,
  input  logic parityErr,
  input  logic biphaseErr,
  input  logic locked,
  input  logic earlyTick,
  input  logic syncTick,
  output logic cOut,
  output logic uOut,
  output logic cblOut,
  output logic erfOut,
  output logic verfOut
);
  ctrlStrobes_t strobes;

  cs_flag_ctrl #(.FRAMES(FRAMES), .MARK_FRAMES(MARK_FRAMES)) i_ctrl (
    .clk(clk), .rstN(rstN), .fmtOnEdge(fmtOnEdge), .subStrobe(subStrobe),
    .blockStart(blockStart), .locked(locked), .earlyTick(earlyTick),
    .syncTick(syncTick), .strobes(strobes)
  );

  cs_flag_dp i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .vIn(vIn), .uIn(uIn), .cIn(cIn),
    .parityErr(parityErr), .biphaseErr(biphaseErr), .locked(locked),
    .cOut(cOut), .uOut(uOut), .cblOut(cblOut), .erfOut(erfOut), .verfOut(verfOut)
  );
endmodule

// File: rtl/cs_flag_out_chk.sv
module cs_flag_out_chk (
  input logic clk,
  input logic rstN,
  input logic fmtOnEdge,
  input logic locked,
  input logic earlyTick,
  input logic syncTick,
  input logic cOut,
  input logic uOut,
  input logic cblOut,
  input logic erfOut,
  input logic verfOut
);
  assert_flags_on_sync_R6: assert property (@(posedge clk) disable iff (!rstN)
    !syncTick |=> ($stable(erfOut) && $stable(verfOut)));

  assert_verf_covers_erf_R5: assert property (@(posedge clk) disable iff (!rstN)
    erfOut |-> verfOut);

  assert_unlock_erf_R9: assert property (@(posedge clk) disable iff (!rstN)
    (syncTick && !locked) |=> (erfOut && verfOut));

  assert_early_side_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!fmtOnEdge && !earlyTick) |=> ($stable(cOut) && $stable(uOut) && $stable(cblOut)));

  assert_edge_side_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fmtOnEdge && !syncTick) |=> ($stable(cOut) && $stable(uOut) && $stable(cblOut)));

  assert_reset_low_R1: assert property (@(posedge clk)
    !rstN |=> (!cOut && !uOut && !cblOut && !erfOut && !verfOut));
endmodule

bind cs_flag_out cs_flag_out_chk i_chk (
  .clk(clk), .rstN(rstN), .fmtOnEdge(fmtOnEdge), .locked(locked),
  .earlyTick(earlyTick), .syncTick(syncTick), .cOut(cOut), .uOut(uOut),
  .cblOut(cblOut), .erfOut(erfOut), .verfOut(verfOut)
);

// File: tb/test_cs_flag_out.sv
module test_cs_flag_out;
  logic clk = 1'b0;
  logic rstN, fmtOnEdge, subStrobe, blockStart, vIn, uIn, cIn;
  logic parityErr, biphaseErr, locked, earlyTick, syncTick;
  logic cOut, uOut, cblOut, erfOut, verfOut;

  int checks = 0;
  int fails  = 0;

  // Reference position model
  int  expFrame = 0;
  bit  expRight = 0;
  bit  prevC = 0, prevU = 0, prevCbl = 0, prevErf = 0, prevVerf = 0;
  int  cblHigh;

  always #10 clk = ~clk;

  cs_flag_out i_cs_flag_out (
    .clk(clk), .rstN(rstN), .fmtOnEdge(fmtOnEdge), .subStrobe(subStrobe),
    .blockStart(blockStart), .vIn(vIn), .uIn(uIn), .cIn(cIn),
    .parityErr(parityErr), .biphaseErr(biphaseErr), .locked(locked),
    .earlyTick(earlyTick), .syncTick(syncTick), .cOut(cOut), .uOut(uOut),
    .cblOut(cblOut), .erfOut(erfOut), .verfOut(verfOut)
  );

  // {v, u, c, blockStart, parityErr, biphaseErr}
  localparam logic [5:0] VEC [0:11] = '{
    6'b000100, 6'b111000, 6'b010000, 6'b101010, 6'b000001, 6'b110000,
    6'b001011, 6'b100000, 6'b011000, 6'b000110, 6'b101000, 6'b010001
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runSub(input bit v, input bit u, input bit c, input bit bs,
                        input bit pe, input bit be, input bit doChecks);
    int  pf;
    bit  pr, expCbl, expErf;
    pf = (bs || !locked) ? 0 : expFrame;
    pr = (bs || !locked) ? 0 : expRight;
    expCbl = (pf < 32);
    if (locked) begin
      expRight = ~pr;
      expFrame = pr ? ((pf == 191) ? 0 : pf + 1) : pf;
    end else begin
      expFrame = 0; expRight = 0;
    end
    expErf = pe | be | ~locked;
    subStrobe = 1; blockStart = bs; vIn = v; uIn = u; cIn = c;
    @(negedge clk);
    subStrobe = 0; blockStart = 0; parityErr = pe; biphaseErr = be;
    @(negedge clk);
    parityErr = 0; biphaseErr = 0; earlyTick = 1;
    @(negedge clk);
    earlyTick = 0;
    if (doChecks) begin
      if (!fmtOnEdge) begin
        check(cOut == c, "R7 cOut after early", cOut, c);
        check(uOut == u, "R7 uOut after early", uOut, u);
        check(cblOut == expCbl, "R2 cblOut after early", cblOut, expCbl);
      end else begin
        check(cOut == prevC && uOut == prevU && cblOut == prevCbl,
              "R8 side outputs held at early", {cOut, uOut, cblOut}, {prevC, prevU, prevCbl});
      end
      check(erfOut == prevErf && verfOut == prevVerf, "R6 flags held before sync",
            {erfOut, verfOut}, {prevErf, prevVerf});
    end
    syncTick = 1;
    @(negedge clk);
    syncTick = 0;
    if (doChecks) begin
      check(cOut == c && uOut == u, "R8 c/u after sync", {cOut, uOut}, {c, u});
      check(cblOut == expCbl, "R2 cblOut after sync", cblOut, expCbl);
      check(erfOut == expErf, "R4 erfOut", erfOut, expErf);
      check(verfOut == (v | expErf), "R5 verfOut", verfOut, v | expErf);
    end
    prevC = c; prevU = u; prevCbl = expCbl; prevErf = expErf; prevVerf = v | expErf;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; fmtOnEdge = 0; subStrobe = 0; blockStart = 0; vIn = 0; uIn = 0; cIn = 0;
    parityErr = 0; biphaseErr = 0; locked = 1; earlyTick = 0; syncTick = 0;
    repeat (3) @(negedge clk);
    check({cOut, uOut, cblOut, erfOut, verfOut} == 5'b0, "R1 reset outputs low",
          {cOut, uOut, cblOut, erfOut, verfOut}, 0);
    rstN = 1;
    @(negedge clk);
    // R1: first subframe without preamble is frame 0 -> marker high
    runSub(0, 1, 1, 0, 0, 0, 1);
    check(cblOut == 1, "R1 first subframe marker", cblOut, 1);

    // Vector table walk, early format
    for (int i = 0; i < 12; i++)
      runSub(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], 1);

    // R4: sticky cleared after transfer, so an error-free subframe gives ERF low
    runSub(0, 0, 0, 0, 1, 1, 1);
    runSub(0, 0, 0, 0, 0, 0, 1);
    check(erfOut == 0, "R4 sticky cleared", erfOut, 0);

    // R2/R3: full block after resync, count marker-high subframes
    runSub(0, 0, 1, 1, 0, 0, 1);
    cblHigh = 1;
    for (int i = 1; i < 384; i++) begin
      runSub(i[0], i[1], i[2], 0, 0, 0, 1);
      if (cblOut) cblHigh++;
    end
    check(cblHigh == 64, "R2 marker length per block", cblHigh, 64);
    runSub(0, 0, 0, 0, 0, 0, 1);
    check(cblOut == 1, "R2 wrap after frame 191", cblOut, 1);

    // R3: resync mid-block
    for (int i = 0; i < 80; i++) runSub(0, 0, 0, 0, 0, 0, 0);
    runSub(1, 0, 0, 0, 0, 0, 1);
    check(cblOut == 0, "R3 marker low deep in block", cblOut, 0);
    runSub(0, 0, 0, 1, 0, 0, 1);
    check(cblOut == 1, "R3 preamble restarts block", cblOut, 1);

    // R9: loss of lock
    for (int i = 0; i < 80; i++) runSub(0, 0, 0, 0, 0, 0, 0);
    locked = 0;
    @(negedge clk);
    runSub(0, 1, 0, 0, 0, 0, 1);
    check(erfOut == 1 && verfOut == 1, "R9 flags while unlocked", {erfOut, verfOut}, 3);
    runSub(0, 0, 1, 0, 0, 0, 1);
    locked = 1;
    @(negedge clk);
    runSub(0, 0, 0, 0, 0, 0, 1);
    check(cblOut == 1 && erfOut == 0, "R9 counter held at zero", {cblOut, erfOut}, 2);

    // R8: on-edge format
    fmtOnEdge = 1;
    @(negedge clk);
    for (int i = 0; i < 12; i++)
      runSub(VEC[11-i][5], VEC[11-i][4], VEC[11-i][3], VEC[11-i][2], 0, VEC[11-i][0], 1);

    // R1: reset mid-run clears outputs
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    check({cOut, uOut, cblOut, erfOut, verfOut} == 5'b0, "R1 reset again",
          {cOut, uOut, cblOut, erfOut, verfOut}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule